// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block holds the output cells of a programmable logic device, one cell per pin, grouped into banks of four. Each cell takes the sum-of-products value that the logic array produces for its pin. Its configuration picks one of three storage modes: a pass-through, a flip-flop clocked by the shared clock/latch-enable input, or a level latch that is open while that input is high. An optional inversion is applied after the storage element. The cell then drives its pad and returns one or two feedback signals to the array.

Three global control terms act on every stored value in the device: an asynchronous clear, an asynchronous set and a test preload that forces a supplied value into storage. Each bank has its own output-enable selector. The enable can come from a common enable pin, from two bank product terms combined by AND or XOR, or be held permanently on or off. When a pad is not driven, the pin feedback carries the value that is applied externally to the pad.

Top module: `io_out_macro`

## Requirements
- R1: With mode field `cfgMode[2i+1:2i]` equal to 00 (or the spare code 11), `padOut[i]` equals `sopIn[i] ^ cfgInvert[i]` without waiting for a clock edge.
- R2: With mode 01, cell i stores `sopIn[i]` on each rising edge of `clk` and holds it between edges.
- R3: With mode 10, cell i stores `sopIn[i]` while `clk` is high and holds the last value while `clk` is low.
- R4: While `resetTerm` is high, every register and latch holds 0 at once, without a clock edge, and this overrides `presetTerm`.
- R5: While `presetTerm` is high and `resetTerm` is low, every register and latch holds 1 at once, without a clock edge.
- R6: Inversion is applied after storage: `padOut[i]` equals the stored value XOR `cfgInvert[i]`, including after a preset or a reset.
- R7: While `preloadTerm` is high (and neither clear nor set is active), a register cell takes `preloadData[i]` at the rising edge in place of `sopIn[i]`, and a latch cell takes `preloadData[i]` at once.
- R8: While `rstN` is low, all storage holds 0.
- R9: Bank b enable selector `cfgOeSel[2b+1:2b]`: 00 uses `oePin`, 01 uses the bank product terms, 10 is always on, 11 is always off. `padOe` is equal for all four cells of a bank.
- R10: With selector 01, the bank enable is `oeTermA[b] & oeTermB[b]` when `cfgOeXor[b]` is 0, and `oeTermA[b] ^ oeTermB[b]` when it is 1.
- R11: `fbPin[i]` equals `padOut[i]` when the cell is enabled and `padIn[i]` when it is not. Cells whose bit in `DUAL_FB_MASK` is set also drive `fbStore[i]` with the value before inversion (stored, or pass-through in mode 00). The other cells drive `fbStore[i]` with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock (register mode) and latch enable (latch mode) |
| rstN | input | 1 | Active-low power-up clear of all storage |
| sopIn | input | NUM_CELLS | Sum-of-products value, one per cell |
| presetTerm | input | 1 | Global asynchronous set term, active high |
| resetTerm | input | 1 | Global asynchronous clear term, active high |
| preloadTerm | input | 1 | Global test preload term, active high |
| preloadData | input | NUM_CELLS | Value forced into storage during preload |
| cfgMode | input | 2*NUM_CELLS | Per-cell storage mode |
| cfgInvert | input | NUM_CELLS | Per-cell output inversion |
| cfgOeSel | input | 2*NUM_BANKS | Per-bank output-enable source |
| cfgOeXor | input | NUM_BANKS | Per-bank XOR (1) or AND (0) of the enable terms |
| oePin | input | 1 | Common output-enable pin |
| oeTermA | input | NUM_BANKS | First enable product term per bank |
| oeTermB | input | NUM_BANKS | Second enable product term per bank |
| padIn | input | NUM_CELLS | Externally driven pad value |
| padOut | output | NUM_CELLS | Value driven on the pad |
| padOe | output | NUM_CELLS | Pad driver enable |
| fbStore | output | NUM_CELLS | Stored-value feedback (dual cells only) |
| fbPin | output | NUM_CELLS | Pin feedback into the array |

## Verification
The assertions assume that the clear, set and preload terms change only while `clk` is low and stay steady across each rising edge. Under that assumption, a flip-flop that was neither cleared, set nor preloaded around an edge holds exactly the array value sampled at that edge. The bench changes every input only in the low half of the clock, a nanosecond after the falling edge, and it holds the global terms for whole cycles. As a result, latches never see a control term while they are open, and no asynchronous pulse falls between two sampling points.

// File: rtl/omc_pkg.sv
package omc_pkg;

  typedef enum logic [1:0] {
    STORE_COMB  = 2'b00,
    STORE_REG   = 2'b01,
    STORE_LATCH = 2'b10,
    STORE_SPARE = 2'b11
  } storeMode_e;

  typedef enum logic [1:0] {
    OE_FROM_PIN   = 2'b00,
    OE_FROM_TERMS = 2'b01,
    OE_ALWAYS_ON  = 2'b10,
    OE_ALWAYS_OFF = 2'b11
  } oeSrc_e;

  typedef struct packed {
    logic clrAll;
    logic setAll;
    logic loadAll;
  } ctrlStrobe_t;

endpackage

// File: rtl/io_out_ctrl.sv
module io_out_ctrl
  import omc_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   presetTerm,
  input  logic                   resetTerm,
  input  logic                   preloadTerm,
  input  logic                   oePin,
  input  logic [NUM_BANKS-1:0]   oeTermA,
  input  logic [NUM_BANKS-1:0]   oeTermB,
  input  logic [2*NUM_BANKS-1:0] cfgOeSel,
  input  logic [NUM_BANKS-1:0]   cfgOeXor,
  output ctrlStrobe_t            strobe,
  output logic [NUM_BANKS-1:0]   bankOe
);

  logic clearNow;
  logic setNow;

  // Clear wins over set, and set wins over preload.
  assign clearNow = !rstN || resetTerm;
  assign setNow   = presetTerm && !clearNow;

  always_comb begin
    strobe.clrAll  = clearNow;
    strobe.setAll  = setNow;
    strobe.loadAll = preloadTerm && !clearNow && !setNow;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    oeSrc_e srcSel;
    logic   termMix;

    assign srcSel  = oeSrc_e'(cfgOeSel[2*b +: 2]);
    assign termMix = cfgOeXor[b] ? (oeTermA[b] ^ oeTermB[b])
                                 : (oeTermA[b] & oeTermB[b]);

    always_comb begin
      unique case (srcSel)
        OE_FROM_PIN:   bankOe[b] = oePin;
        OE_FROM_TERMS: bankOe[b] = termMix;
        OE_ALWAYS_ON:  bankOe[b] = 1'b1;
        default:       bankOe[b] = 1'b0;
      endcase
    end

    assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cfgOeSel[2*b +: 2] == 2'b11) |-> !bankOe[b]);

    assert_oe_on_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cfgOeSel[2*b +: 2] == 2'b10) |-> bankOe[b]);

    assert_xor_equal_terms_R10: assert property (@(posedge clk) disable iff (!rstN)
      ((cfgOeSel[2*b +: 2] == 2'b01) && cfgOeXor[b] && (oeTermA[b] == oeTermB[b]))
      |-> !bankOe[b]);
  end

endmodule

// File: rtl/io_out_datapath.sv
module io_out_datapath
  import omc_pkg::*;
#(
  parameter int          NUM_BANKS    = 2,
  parameter int          BANK_SIZE    = 4,
  parameter logic [63:0] DUAL_FB_MASK = 64'h0000_0000_0000_000F
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [NUM_BANKS-1:0]   bankOe,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   sopIn,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   preloadData,
  input  logic [2*NUM_BANKS*BANK_SIZE-1:0] cfgMode,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   cfgInvert,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   padIn,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   padOut,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   padOe,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   fbStore,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   fbPin
);

  localparam int NUM_CELLS = NUM_BANKS * BANK_SIZE;

  logic clrS, setS, loadS;
  logic [NUM_CELLS-1:0] regVec;
  logic [NUM_CELLS-1:0] latVec;

  assign clrS  = strobe.clrAll;
  assign setS  = strobe.setAll;
  assign loadS = strobe.loadAll;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    storeMode_e modeSel;
    logic regQ;
    logic latQ;
    logic coreVal;
    logic pinVal;
    logic cellOe;

    assign modeSel = storeMode_e'(cfgMode[2*i +: 2]);
    assign cellOe  = bankOe[i / BANK_SIZE];

    // Edge-triggered storage with asynchronous clear and set.
    always_ff @(posedge clk or posedge clrS or posedge setS) begin
      if (clrS)       regQ <= 1'b0;
      else if (setS)  regQ <= 1'b1;
      else if (loadS) regQ <= preloadData[i];
      else            regQ <= sopIn[i];
    end

    // Level storage: open while the shared clock input is high.
    always_latch begin
      if (clrS)       latQ = 1'b0;
      else if (setS)  latQ = 1'b1;
      else if (loadS) latQ = preloadData[i];
      else if (clk)   latQ = sopIn[i];
    end

    always_comb begin
      unique case (modeSel)
        STORE_REG:   coreVal = regQ;
        STORE_LATCH: coreVal = latQ;
        default:     coreVal = sopIn[i];
      endcase
    end

    assign padOut[i] = coreVal ^ cfgInvert[i];
    assign padOe[i]  = cellOe;
    assign pinVal    = cellOe ? padOut[i] : padIn[i];
    assign fbPin[i]  = pinVal;

    if (DUAL_FB_MASK[i]) begin : g_dual
      assign fbStore[i] = coreVal;
    end else begin : g_single
      assign fbStore[i] = 1'b0;
    end

    assign regVec[i] = regQ;
    assign latVec[i] = latQ;
  end

  assert_reg_capture_R2: assert property (@(posedge clk)
    disable iff (clrS || setS)
    !loadS |=> (regVec == $past(sopIn)));

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrS |-> ((regVec == '0) && (latVec == '0)));

  assert_set_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    setS |-> ((regVec == '1) && (latVec == '1)));

  assert_power_clear_R8: assert property (@(posedge clk)
    !rstN |-> (regVec == '0));

endmodule

// File: rtl/io_out_macro.sv
module io_out_macro
  import omc_pkg::*;
#(
  parameter int          NUM_BANKS    = 2,
  parameter int          BANK_SIZE    = 4,
  parameter logic [63:0] DUAL_FB_MASK = 64'h0000_0000_0000_000F
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   sopIn,
  input  logic                             presetTerm,
  input  logic                             resetTerm,
  input  logic                             preloadTerm,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   preloadData,
  input  logic [2*NUM_BANKS*BANK_SIZE-1:0] cfgMode,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   cfgInvert,
  input  logic [2*NUM_BANKS-1:0]           cfgOeSel,
  input  logic [NUM_BANKS-1:0]             cfgOeXor,
  input  logic                             oePin,
  input  logic [NUM_BANKS-1:0]             oeTermA,
  input  logic [NUM_BANKS-1:0]             oeTermB,
  input  logic [NUM_BANKS*BANK_SIZE-1:0]   padIn,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   padOut,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   padOe,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   fbStore,
  output logic [NUM_BANKS*BANK_SIZE-1:0]   fbPin
);

  ctrlStrobe_t          strobe;
  logic [NUM_BANKS-1:0] bankOe;

  io_out_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .presetTerm  (presetTerm),
    .resetTerm   (resetTerm),
    .preloadTerm (preloadTerm),
    .oePin       (oePin),
    .oeTermA     (oeTermA),
    .oeTermB     (oeTermB),
    .cfgOeSel    (cfgOeSel),
    .cfgOeXor    (cfgOeXor),
    .strobe      (strobe),
    .bankOe      (bankOe)
  );

  io_out_datapath #(
    .NUM_BANKS    (NUM_BANKS),
    .BANK_SIZE    (BANK_SIZE),
    .DUAL_FB_MASK (DUAL_FB_MASK)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .bankOe      (bankOe),
    .sopIn       (sopIn),
    .preloadData (preloadData),
    .cfgMode     (cfgMode),
    .cfgInvert   (cfgInvert),
    .padIn       (padIn),
    .padOut      (padOut),
    .padOe       (padOe),
    .fbStore     (fbStore),
    .fbPin       (fbPin)
  );

endmodule

// File: tb/sim_io_out_macro.sv
`timescale 1ns/1ps
module sim_io_out_macro;

  localparam int NB = 2;
  localparam int BS = 4;
  localparam int NC = NB * BS;
  localparam logic [63:0] DUAL = 64'h0000_0000_0000_000F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0] sopIn = '0;
  logic presetTerm = 1'b0, resetTerm = 1'b0, preloadTerm = 1'b0;
  logic [NC-1:0] preloadData = '0;
  logic [2*NC-1:0] cfgMode = '0;
  logic [NC-1:0] cfgInvert = '0;
  logic [2*NB-1:0] cfgOeSel = '0;
  logic [NB-1:0] cfgOeXor = '0;
  logic oePin = 1'b0;
  logic [NB-1:0] oeTermA = '0, oeTermB = '0;
  logic [NC-1:0] padIn = '0;
  wire  [NC-1:0] padOut, padOe, fbStore, fbPin;

  int vectors = 0;
  int miscompares = 0;
  bit regM [NC];
  bit latM [NC];

  always #5 clk = ~clk;

  io_out_macro #(.NUM_BANKS(NB), .BANK_SIZE(BS), .DUAL_FB_MASK(DUAL)) u0 (
    .clk(clk), .rstN(rstN), .sopIn(sopIn), .presetTerm(presetTerm),
    .resetTerm(resetTerm), .preloadTerm(preloadTerm), .preloadData(preloadData),
    .cfgMode(cfgMode), .cfgInvert(cfgInvert), .cfgOeSel(cfgOeSel),
    .cfgOeXor(cfgOeXor), .oePin(oePin), .oeTermA(oeTermA), .oeTermB(oeTermB),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .fbStore(fbStore), .fbPin(fbPin)
  );

  task automatic lowPhase();
    @(negedge clk);
    #1;
  endtask

  task automatic compare(input string tag);
    logic [NC-1:0] eOut, eOe, eStore, ePin;
    bit bad;
    for (int i = 0; i < NC; i++) begin
      int m;
      int b;
      bit core;
      bit oe;
      m = cfgMode[2*i +: 2];
      b = i / BS;
      if (m == 1) core = regM[i];
      else if (m == 2) core = latM[i];
      else core = sopIn[i];
      case (cfgOeSel[2*b +: 2])
        2'b00: oe = oePin;
        2'b01: oe = cfgOeXor[b] ? (oeTermA[b] ^ oeTermB[b]) : (oeTermA[b] & oeTermB[b]);
        2'b10: oe = 1'b1;
        default: oe = 1'b0;
      endcase
      eOut[i]   = core ^ cfgInvert[i];
      eOe[i]    = oe;
      ePin[i]   = oe ? eOut[i] : padIn[i];
      eStore[i] = DUAL[i] ? core : 1'b0;
    end
    vectors++;
    bad = 0;
    if (padOut !== eOut) begin
      bad = 1;
      $display("FAIL %s padOut actual %h expected %h", tag, padOut, eOut);
    end
    if (padOe !== eOe) begin
      bad = 1;
      $display("FAIL %s padOe actual %h expected %h", tag, padOe, eOe);
    end
    if (fbStore !== eStore) begin
      bad = 1;
      $display("FAIL %s fbStore actual %h expected %h", tag, fbStore, eStore);
    end
    if (fbPin !== ePin) begin
      bad = 1;
      $display("FAIL %s fbPin actual %h expected %h", tag, fbPin, ePin);
    end
    if (bad) miscompares++;
  endtask

  // Called in the low phase after inputs change: apply asynchronous
  // effects, check, then advance the model across the rising edge.
  task automatic step(input string tag);
    bit clrNow;
    clrNow = !rstN || resetTerm;
    for (int i = 0; i < NC; i++) begin
      if (clrNow) begin regM[i] = 0; latM[i] = 0; end
      else if (presetTerm) begin regM[i] = 1; latM[i] = 1; end
      else if (preloadTerm) latM[i] = preloadData[i];
    end
    #3;
    compare(tag);
    @(posedge clk);
    for (int i = 0; i < NC; i++) begin
      bit v;
      if (clrNow) v = 0;
      else if (presetTerm) v = 1;
      else if (preloadTerm) v = preloadData[i];
      else v = sopIn[i];
      regM[i] = v;
      latM[i] = v;
    end
  endtask

  task automatic runSop(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      lowPhase();
      sopIn = NC'($urandom);
      step(tag);
    end
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin regM[i] = 0; latM[i] = 0; end
    // R8: power-up clear, register and latch cells
    cfgMode  = {NB*BS/2{4'b1001}};
    cfgOeSel = {NB{2'b10}};
    runSop("R8 power-up clear", 4);
    lowPhase(); rstN = 1'b1; step("R8 release");

    // R1: pass-through, plus spare code 11
    cfgMode = '0;
    runSop("R1 combinational", 12);
    cfgMode = {NC{2'b11}};
    runSop("R1 spare mode", 6);

    // R2: registers
    cfgMode = {NC{2'b01}};
    runSop("R2 register", 16);

    // R3: latches
    cfgMode = {NC{2'b10}};
    runSop("R3 latch", 16);

    // R6: random inversion with mixed modes
    for (int k = 0; k < 24; k++) begin
      lowPhase();
      cfgMode   = (2*NC)'($urandom);
      cfgInvert = NC'($urandom);
      sopIn     = NC'($urandom);
      step("R6 polarity");
    end

    // R5: preset pulses
    cfgMode = {NB*BS/2{4'b0110}};
    for (int k = 0; k < 20; k++) begin
      lowPhase();
      presetTerm = ($urandom % 3) == 0;
      sopIn      = NC'($urandom);
      cfgInvert  = NC'($urandom);
      step("R5 preset");
    end
    lowPhase(); presetTerm = 1'b0; step("R5 release");

    // R4: reset pulses, with and without preset held
    for (int k = 0; k < 24; k++) begin
      lowPhase();
      resetTerm  = ($urandom % 3) == 0;
      presetTerm = ($urandom % 2) == 0;
      sopIn      = NC'($urandom);
      step("R4 reset priority");
    end
    lowPhase(); resetTerm = 1'b1; presetTerm = 1'b1; step("R4 both asserted");
    lowPhase(); resetTerm = 1'b0; presetTerm = 1'b0; step("R4 release");

    // R7: preload
    for (int k = 0; k < 20; k++) begin
      lowPhase();
      preloadTerm = ($urandom % 2) == 0;
      preloadData = NC'($urandom);
      sopIn       = NC'($urandom);
      step("R7 preload");
    end
    lowPhase(); preloadTerm = 1'b0; step("R7 release");

    // R9/R10/R11: enable sources, term mixing, feedback
    for (int k = 0; k < 40; k++) begin
      lowPhase();
      cfgOeSel = (2*NB)'($urandom);
      cfgOeXor = NB'($urandom);
      oePin    = 1'($urandom);
      oeTermA  = NB'($urandom);
      oeTermB  = NB'($urandom);
      padIn    = NC'($urandom);
      sopIn    = NC'($urandom);
      cfgMode  = (2*NC)'($urandom);
      if (k < 14) step("R9 oe source");
      else if (k < 28) step("R10 term mix");
      else step("R11 feedback");
    end
    cfgOeSel = {NB{2'b01}};
    for (int k = 0; k < 8; k++) begin
      lowPhase();
      cfgOeXor = NB'(k);
      oeTermA  = NB'(k >> 1);
      oeTermB  = NB'(k >> 2);
      padIn    = NC'($urandom);
      step("R10 term mix sweep");
    end

    // R8: mid-run clear
    cfgMode = {NC{2'b01}};
    runSop("R8 prefill", 3);
    lowPhase(); rstN = 1'b0; step("R8 mid-run clear");
    lowPhase(); rstN = 1'b1; step("R8 mid-run release");
    runSop("R2 after clear", 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule